// File: doc/BRIEF.md
# Prescaled Data Timeout Monitor

This block times how long a card-interface command sequence has been running. A free-running divider turns the system clock into a slow tick, one every `PRESCALE` cycles (10000 by default). A saturating tick counter is zeroed and armed by a sequence-start strobe. It advances on each tick while the sequence is open, and it is zeroed and disarmed by a sequence-end or abort strobe.

When the counted ticks reach the programmed limit, the block enters a timeout error state. If the interrupt enable is high, it also sets a sticky interrupt flag. The counter does not stop at the limit, so every later tick raises the set condition again. Software clears the flag with a one-cycle strobe. To stop the repeats it must first abort the sequence. The timeout therefore falls between `(limit-1)*PRESCALE` and `limit*PRESCALE` cycles after the start, depending on where the divider is in its period.

Top module: `dtmo_monitor`

## Requirements
- R1: The divider runs from reset onward and is never restarted by a sequence strobe. It produces exactly one tick every `PRESCALE` cycles, so two consecutive timeout set conditions lie exactly `PRESCALE` cycles apart.
- R2: `seq_start` zeroes the tick counter and opens the sequence, including when a sequence is already open. Ticks are counted only while the sequence is open.
- R3: When the tick that brings the count to `limit` or above arrives, `timeout_err` rises. Measured from the edge that samples `seq_start`, this happens in a cycle between `(max(limit,1)-1)*PRESCALE+1` and `max(limit,1)*PRESCALE`.
- R4: `irq_flag` is set by a timeout condition only when `irq_en` is 1 in that cycle. `timeout_err` rises whatever the value of `irq_en`.
- R5: Every tick that arrives while the sequence is open and the count is at or above `limit` is a new set condition. After software clears the flag, it is set again on the next tick.
- R6: `seq_end` or `seq_abort` zeroes the counter, closes the sequence and drops `timeout_err` on the next edge. No further set condition occurs until a new start.
- R7: `flag_clr` lowers `irq_flag` one edge later, unless a set condition arrives in the same cycle, in which case the flag stays 1.
- R8: The counter saturates at all ones instead of wrapping. With `limit` at all ones, set conditions keep recurring on every tick.
- R9: After reset, `irq_flag` and `timeout_err` are 0. The divider, the counter and the sequence state are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| seq_start | input | 1 | One-cycle strobe: command sequence begins |
| seq_end | input | 1 | One-cycle strobe: command sequence completed |
| seq_abort | input | 1 | One-cycle strobe: software aborted the sequence |
| limit | input | COUNT_W | Timeout limit in prescaler ticks |
| irq_en | input | 1 | Timeout interrupt enable |
| flag_clr | input | 1 | One-cycle strobe clearing the interrupt flag |
| irq_flag | output | 1 | Sticky timeout interrupt flag |
| timeout_err | output | 1 | Timeout error state, level |

## Verification
A divider that drifts or is restarted by a start strobe moves the moment `timeout_err` rises out of its one-period window. It also changes the exact `PRESCALE`-cycle spacing between repeated flag sets, and both show within one timeout. A counter that wraps instead of saturating, or that is not zeroed by a restart, shows as a missing repeat or as a timeout that comes too early. In both cases this appears a single tick after the faulty count. A stale error state or flag after an end or abort is visible at the outputs one edge after the strobe.

// File: rtl/dtmo_pkg.sv
package dtmo_pkg;
   localparam int unsigned DTMO_PRESCALE_DEF = 10000;
   localparam int unsigned DTMO_COUNT_W_DEF  = 16;

   typedef enum logic [1:0] {
      SEQ_HOLD  = 2'd0,
      SEQ_STOP  = 2'd1,
      SEQ_LOAD  = 2'd2,
      SEQ_COUNT = 2'd3
   } seq_op_e;
endpackage

// File: rtl/dtmo_prescaler.sv
module dtmo_prescaler #(
   parameter int unsigned PRESCALE = dtmo_pkg::DTMO_PRESCALE_DEF
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

   generate
      if (PRESCALE == 1) begin : g_bypass
         assign tick = 1'b1;
      end else begin : g_divide
         logic [PW-1:0] phase;
         logic          wrap;

         assign wrap = (phase == PW'(PRESCALE - 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    phase <= '0;
            else if (wrap) phase <= '0;
            else           phase <= phase + 1'b1;
         end

         assign tick = wrap;
      end
   endgenerate
endmodule

// File: rtl/dtmo_seq_counter.sv
module dtmo_seq_counter
   import dtmo_pkg::*;
#(
   parameter int unsigned COUNT_W = DTMO_COUNT_W_DEF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               seq_start,
   input  logic               seq_stop,
   input  logic               tick,
   input  logic [COUNT_W-1:0] limit,
   output logic               busy,
   output logic [COUNT_W-1:0] tick_cnt,
   output logic               hit
);
   localparam logic [COUNT_W-1:0] CNT_MAX = '1;

   seq_op_e            op;
   logic [COUNT_W-1:0] cnt_next;

   assign cnt_next = (tick_cnt == CNT_MAX) ? CNT_MAX : tick_cnt + 1'b1;

   always_comb begin
      if (seq_stop)          op = SEQ_STOP;
      else if (seq_start)    op = SEQ_LOAD;
      else if (busy && tick) op = SEQ_COUNT;
      else                   op = SEQ_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         tick_cnt <= '0;
      end else begin
         case (op)
            SEQ_STOP: begin
               busy     <= 1'b0;
               tick_cnt <= '0;
            end
            SEQ_LOAD: begin
               busy     <= 1'b1;
               tick_cnt <= '0;
            end
            SEQ_COUNT: tick_cnt <= cnt_next;
            default:   tick_cnt <= tick_cnt;
         endcase
      end
   end

   assign hit = (op == SEQ_COUNT) && (cnt_next >= limit);
endmodule

// File: rtl/dtmo_flag_unit.sv
module dtmo_flag_unit (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic seq_stop,
   input  logic irq_en,
   input  logic flag_clr,
   output logic irq_flag,
   output logic timeout_err
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        timeout_err <= 1'b0;
      else if (seq_stop) timeout_err <= 1'b0;
      else if (hit)      timeout_err <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             irq_flag <= 1'b0;
      else if (hit && irq_en) irq_flag <= 1'b1;
      else if (flag_clr)      irq_flag <= 1'b0;
   end
endmodule

// File: rtl/dtmo_monitor.sv
module dtmo_monitor #(
   parameter int unsigned PRESCALE = dtmo_pkg::DTMO_PRESCALE_DEF,
   parameter int unsigned COUNT_W  = dtmo_pkg::DTMO_COUNT_W_DEF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               seq_start,
   input  logic               seq_end,
   input  logic               seq_abort,
   input  logic [COUNT_W-1:0] limit,
   input  logic               irq_en,
   input  logic               flag_clr,
   output logic               irq_flag,
   output logic               timeout_err
);
   generate
      if (PRESCALE < 1) begin : g_bad_prescale
         $error("dtmo_monitor: PRESCALE must be at least 1");
      end
      if (COUNT_W < 2 || COUNT_W > 32) begin : g_bad_width
         $error("dtmo_monitor: COUNT_W must lie in 2..32");
      end
   endgenerate

   logic               tick;
   logic               seq_stop;
   logic               busy;
   logic [COUNT_W-1:0] tick_cnt;
   logic               hit;

   assign seq_stop = seq_end | seq_abort;

   dtmo_prescaler #(.PRESCALE(PRESCALE)) i_prescaler (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   dtmo_seq_counter #(.COUNT_W(COUNT_W)) i_seq_counter (
      .clk       (clk),
      .rst_n     (rst_n),
      .seq_start (seq_start),
      .seq_stop  (seq_stop),
      .tick      (tick),
      .limit     (limit),
      .busy      (busy),
      .tick_cnt  (tick_cnt),
      .hit       (hit)
   );

   dtmo_flag_unit i_flag_unit (
      .clk         (clk),
      .rst_n       (rst_n),
      .hit         (hit),
      .seq_stop    (seq_stop),
      .irq_en      (irq_en),
      .flag_clr    (flag_clr),
      .irq_flag    (irq_flag),
      .timeout_err (timeout_err)
   );
endmodule

// File: rtl/dtmo_monitor_chk.sv
module dtmo_monitor_chk #(
   parameter int unsigned PRESCALE = 10000,
   parameter int unsigned COUNT_W  = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               seq_start,
   input logic               seq_end,
   input logic               seq_abort,
   input logic               irq_en,
   input logic               tick,
   input logic               busy,
   input logic [COUNT_W-1:0] tick_cnt,
   input logic               hit,
   input logic               irq_flag,
   input logic               timeout_err
);
   // R6: an end or abort strobe empties the sequence state on the next edge
   a_r6_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_end || seq_abort) |=> (!timeout_err && !busy && tick_cnt == '0));

   // R2: a closed sequence holds a zero count
   a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (tick_cnt == '0));

   // R3: a set condition puts the block into the error state
   a_r3_err_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> timeout_err);

   // R4: the flag only rises from an enabled set condition
   a_r4_flag_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flag) |-> $past(hit && irq_en));

   // R7: set takes priority over a simultaneous clear
   a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && irq_en) |=> irq_flag);

   // R8: the counter holds at its ceiling
   a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && tick_cnt == '1 && !seq_start && !seq_end && !seq_abort)
         |=> (tick_cnt == '1));

   // R1: ticks are single-cycle pulses when the divider is active
   generate
      if (PRESCALE > 1) begin : g_tick_chk
         a_r1_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate
endmodule

bind dtmo_monitor dtmo_monitor_chk #(.PRESCALE(PRESCALE), .COUNT_W(COUNT_W)) i_dtmo_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .seq_start   (seq_start),
   .seq_end     (seq_end),
   .seq_abort   (seq_abort),
   .irq_en      (irq_en),
   .tick        (tick),
   .busy        (busy),
   .tick_cnt    (tick_cnt),
   .hit         (hit),
   .irq_flag    (irq_flag),
   .timeout_err (timeout_err)
);

// File: tb/test_dtmo_monitor.sv
module test_dtmo_monitor;
   localparam int unsigned P  = 16;
   localparam int unsigned CW = 4;
   localparam int          NV = 6;
   localparam int VLIM [NV] = '{1, 2, 3, 0, 5, 4};
   localparam int VEN  [NV] = '{1, 0, 1, 1, 1, 0};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          seq_start = 1'b0, seq_end = 1'b0, seq_abort = 1'b0;
   logic [CW-1:0] limit = '0;
   logic          irq_en = 1'b0, flag_clr = 1'b0;
   logic          irq_flag, timeout_err;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;

   always #10 clk = ~clk;

   dtmo_monitor #(.PRESCALE(P), .COUNT_W(CW)) i_dtmo_monitor (
      .clk(clk), .rst_n(rst_n), .seq_start(seq_start), .seq_end(seq_end),
      .seq_abort(seq_abort), .limit(limit), .irq_en(irq_en),
      .flag_clr(flag_clr), .irq_flag(irq_flag), .timeout_err(timeout_err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic pulse_abort();
      @(negedge clk) seq_abort = 1'b1;
      @(negedge clk) seq_abort = 1'b0;
   endtask

   task automatic pulse_clr();
      @(negedge clk) flag_clr = 1'b1;
      @(negedge clk) flag_clr = 1'b0;
   endtask

   // Starts a sequence and returns edges from the start edge to the error edge.
   task automatic start_and_wait(input int lim, output int d);
      int cap;
      cap = ((lim < 1 ? 1 : lim) + 2) * P;
      @(negedge clk) seq_start = 1'b1;
      @(negedge clk) seq_start = 1'b0;
      d = 0;
      while (!timeout_err && d < cap) begin
         @(negedge clk);
         d++;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int d;
      int le;
      repeat (3) @(negedge clk);
      // R9: reset state
      chk(irq_flag == 1'b0, "R9 flag after reset", irq_flag, 0);
      chk(timeout_err == 1'b0, "R9 err after reset", timeout_err, 0);
      @(negedge clk) rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // Table walk: R3 window, R4 enable gating
      for (int i = 0; i < NV; i++) begin
         pulse_abort();
         pulse_clr();
         limit  = CW'(VLIM[i]);
         irq_en = VEN[i][0];
         le = (VLIM[i] < 1) ? 1 : VLIM[i];
         start_and_wait(VLIM[i], d);
         chk(timeout_err == 1'b1, "R3 error reached", timeout_err, 1);
         chk(d >= (le - 1) * P + 1, "R3 latency low bound", d, (le - 1) * P + 1);
         chk(d <= le * P, "R3 latency high bound", d, le * P);
         chk(irq_flag == VEN[i][0], "R4 flag follows enable", irq_flag, VEN[i]);
      end

      // R5, R7, R1: recurrence, set-over-clear, exact period
      pulse_abort();
      pulse_clr();
      limit = 4'd2; irq_en = 1'b1;
      start_and_wait(2, d);
      chk(irq_flag == 1'b1, "R5 flag on first hit", irq_flag, 1);
      flag_clr = 1'b1;
      @(negedge clk) flag_clr = 1'b0;
      chk(irq_flag == 1'b0, "R7 clear alone lowers flag", irq_flag, 0);
      repeat (P - 2) @(negedge clk);
      flag_clr = 1'b1;
      @(negedge clk) flag_clr = 1'b0;
      chk(irq_flag == 1'b1, "R7 set wins over clear", irq_flag, 1);
      flag_clr = 1'b1;
      @(negedge clk) flag_clr = 1'b0;
      chk(irq_flag == 1'b0, "R5 cleared again", irq_flag, 0);
      repeat (P - 2) @(negedge clk);
      chk(irq_flag == 1'b0, "R1 no early recurrence", irq_flag, 0);
      @(negedge clk);
      chk(irq_flag == 1'b1, "R1 R5 recurrence after one period", irq_flag, 1);

      // R6: abort drops error, stops repeats
      flag_clr = 1'b1;
      seq_abort = 1'b1;
      @(negedge clk) begin flag_clr = 1'b0; seq_abort = 1'b0; end
      chk(timeout_err == 1'b0, "R6 abort drops error", timeout_err, 0);
      pulse_clr();
      repeat (3 * P) @(negedge clk);
      chk(irq_flag == 1'b0, "R6 no flag after abort", irq_flag, 0);
      chk(timeout_err == 1'b0, "R6 no error after abort", timeout_err, 0);

      // R6: normal end drops error
      limit = 4'd1;
      start_and_wait(1, d);
      chk(timeout_err == 1'b1, "R6 setup error", timeout_err, 1);
      @(negedge clk) seq_end = 1'b1;
      @(negedge clk) seq_end = 1'b0;
      chk(timeout_err == 1'b0, "R6 end drops error", timeout_err, 0);
      pulse_clr();

      // R2: restart mid-sequence zeroes the count
      limit = 4'd3;
      @(negedge clk) seq_start = 1'b1;
      @(negedge clk) seq_start = 1'b0;
      repeat (2 * P) @(negedge clk);
      start_and_wait(3, d);
      chk(d >= 2 * P + 1, "R2 restart zeroes count", d, 2 * P + 1);
      chk(d <= 3 * P, "R2 restart window high", d, 3 * P);

      // R8: saturation at all ones keeps recurring
      pulse_abort();
      pulse_clr();
      limit = '1; irq_en = 1'b1;
      start_and_wait(15, d);
      chk(timeout_err == 1'b1, "R8 reached ceiling", timeout_err, 1);
      repeat (3 * P) @(negedge clk);
      pulse_clr();
      chk(irq_flag == 1'b0, "R8 flag cleared", irq_flag, 0);
      repeat (P + 1) @(negedge clk);
      chk(irq_flag == 1'b1, "R8 recurs at ceiling", irq_flag, 1);
      pulse_abort();

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule